// File: doc/BRIEF.md
# Prefetching Bus Interface Unit

This block sits between an execution unit and an 8-bit external bus. It runs every transfer as a four-clock bus cycle (T1, T2, T3, T4). When the bus is otherwise free, it keeps a small instruction prefetch queue topped up on its own by fetching one byte per bus cycle from a running fetch pointer. The execution unit reaches the bus through a one-deep command slot. Each command is a memory or I/O read or write of one byte or one 16-bit word, and a word is carried as two byte cycles. The outcome comes back through a one-deep result slot that holds the read data, or a zero acknowledge for a write.

An execution-unit command takes priority over prefetching when the bus is parked at T1. A command can also land in the slot while an opcode fetch is in its first clock. In that case the fetch is dropped at its T2, two idle clocks follow, and the command's own cycle starts next. The dropped fetch leaves nothing in the queue. A flush empties the queue and restarts fetching from a new address; a fetch already on the bus is thrown away. An external master can take the bus with a hold request. The unit hands the bus over only at a T1 boundary, never between the two halves of a word, and never while the execution unit signals a locked sequence.

Top module: `fetch_bus_unit`

## Requirements
- R1: Every bus cycle occupies four consecutive clocks, with `bus_tstate` showing 0 (T1), 1 (T2), 2 (T3), 3 (T4). `bus_ale` and the address appear in T1. `bus_rd` or `bus_wr` is high in T2 and T3. Read data is sampled at the end of T3. The result or queue byte is visible in the clock after T4, which is the next T1.
- R2: With the queue full and no command ready to run, the unit stays in T1 (`bus_tstate`=0) with `bus_ale`, `bus_rd` and `bus_wr` low.
- R3: While the queue (4 bytes) has a free byte and nothing else claims the bus, the unit fetches bytes from consecutive addresses. `q_byte` presents them oldest first, and `q_pop` removes the head.
- R4: `cmd_ready` is high only while the command slot is empty, and a command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_op[0]`=1 means write and `cmd_op[1]`=1 means I/O space (`bus_io` high). A result stays in the slot, unchanged, until `rsp_take`, and no further command cycle starts while it is there.
- R5: A byte read returns {8'h00, data}. A word read returns {high byte, low byte}. A write returns 16'h0000.
- R6: A word access runs as two byte cycles back to back: the low byte at the given address, then the high byte at address+1. No bus hold is granted between them.
- R7: At T1, a pending command is started in preference to a prefetch.
- R8: If the command slot fills during a fetch's T1, that fetch's T2 is followed by two idle clocks (`bus_tstate`=4) and then the command's T1. The aborted byte is not queued and is fetched again later.
- R9: `flush_req` empties the queue by the next clock, discards any fetch in flight, and fetching resumes at `flush_addr`.
- R10: A hold request is granted from T1: `bus_tstate`=5 and `hold_ack`=1 on the next clock. Dropping `hold_req` returns the unit to T1 on the following clock.
- R11: While `eu_lock` is high, the unit does not grant a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the execution unit |
| cmd_ready | output | 1 | Command slot empty |
| cmd_op | input | 2 | bit0 write, bit1 I/O space |
| cmd_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cmd_addr | input | AW | Command address |
| cmd_wdata | input | 16 | Write data |
| eu_lock | input | 1 | Locked sequence in progress, no bus hand-over |
| rsp_valid | output | 1 | Result slot full |
| rsp_data | output | 16 | Read data or zero acknowledge |
| rsp_take | input | 1 | Result consumed |
| flush_req | input | 1 | Empty queue and redirect fetching |
| flush_addr | input | AW | New fetch address |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Oldest queued byte |
| q_pop | input | 1 | Remove oldest byte |
| bus_tstate | output | 3 | 0 T1, 1 T2, 2 T3, 3 T4, 4 idle, 5 held |
| bus_ale | output | 1 | Address valid, cycle start |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | I/O space cycle |
| bus_wdata | output | 8 | Write data byte |
| bus_rdata | input | 8 | Read data byte |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus handed over |

## Verification
The assertions check the cycle-level rules on every clock. After T3 comes T4, and after T4 comes T1. An aborted fetch is followed by exactly two idle clocks and then T1. No hold is granted under lock or between word halves. A pending result stays stable, the queue never overflows, a flush leaves the queue empty, and an abort leaves the queue count untouched. Other behaviour can only be shown by the bench scenarios, because it depends on data values across several cycles. This covers the clock at which a result appears, low-before-high byte order and the assembled word, command priority over prefetch, and the refetch of an aborted byte. It also covers the loss of a fetch that a flush overtakes and the order of bytes leaving the queue.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  typedef enum logic [2:0] {
    TS_T1   = 3'd0,
    TS_T2   = 3'd1,
    TS_T3   = 3'd2,
    TS_T4   = 3'd3,
    TS_TI   = 3'd4,
    TS_HOLD = 3'd5
  } tstate_e;

  localparam int OP_WRITE_BIT = 0;
  localparam int OP_IO_BIT    = 1;
endpackage

// File: rtl/fbu_prefetch_q.sv
module fbu_prefetch_q #(
  parameter int              DEPTH      = 4,
  parameter int              AW         = 20,
  parameter logic [AW-1:0]   RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          fetch_start,
  input  logic          fetch_end,
  input  logic          fetch_abort,
  input  logic [7:0]    fetch_byte,
  input  logic          pop,
  output logic          q_valid,
  output logic [7:0]    q_byte,
  output logic          room,
  output logic [AW-1:0] fetch_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_n, wr_ptr_q, wr_ptr_n;
  logic [CW-1:0] count_q, count_n;
  logic [AW-1:0] fptr_q, fptr_n;
  logic          inflight_q, inflight_n, stale_q, stale_n;
  logic          do_wr, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign do_wr      = fetch_end && !stale_q && !flush;
  assign do_pop     = pop && (count_q != '0) && !flush;
  assign q_valid    = (count_q != '0);
  assign q_byte     = mem[rd_ptr_q];
  assign room       = (count_q != FULL_CNT);
  assign fetch_addr = fptr_q;

  always_comb begin
    rd_ptr_n   = rd_ptr_q;
    wr_ptr_n   = wr_ptr_q;
    count_n    = count_q;
    fptr_n     = fptr_q;
    inflight_n = inflight_q;
    stale_n    = stale_q;
    if (fetch_start) begin
      inflight_n = 1'b1;
      stale_n    = flush;
    end else if (fetch_end || fetch_abort) begin
      inflight_n = 1'b0;
      stale_n    = 1'b0;
    end else if (flush && inflight_q) begin
      stale_n = 1'b1;
    end
    if (flush) begin
      rd_ptr_n = '0;
      wr_ptr_n = '0;
      count_n  = '0;
      fptr_n   = flush_addr;
    end else begin
      if (do_wr) begin
        wr_ptr_n = ptr_inc(wr_ptr_q);
        fptr_n   = fptr_q + AW'(1);
      end
      if (do_pop) rd_ptr_n = ptr_inc(rd_ptr_q);
      case ({do_wr, do_pop})
        2'b10:   count_n = count_q + CW'(1);
        2'b01:   count_n = count_q - CW'(1);
        default: count_n = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q   <= '0;
      wr_ptr_q   <= '0;
      count_q    <= '0;
      fptr_q     <= RESET_ADDR;
      inflight_q <= 1'b0;
      stale_q    <= 1'b0;
    end else begin
      rd_ptr_q   <= rd_ptr_n;
      wr_ptr_q   <= wr_ptr_n;
      count_q    <= count_n;
      fptr_q     <= fptr_n;
      inflight_q <= inflight_n;
      stale_q    <= stale_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= fetch_byte;
  end

  // R3: a completed fetch never finds the queue already full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_end && !stale_q && !flush) |-> (count_q != FULL_CNT));
  // R9: the queue is empty in the clock after a flush
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));
  // R8: an abort alone leaves the queue occupancy unchanged
  p_abort_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_abort && !pop && !flush) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/fbu_eu_slot.sv
module fbu_eu_slot
  import fbu_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_word,
  input  logic [AW-1:0] cmd_addr,
  input  logic [15:0]   cmd_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  input  logic          rsp_take,
  output logic          eu_req,
  output logic [AW-1:0] eu_addr,
  output logic          eu_write,
  output logic          eu_io,
  output logic [7:0]    eu_wbyte,
  output logic          eu_mid,
  input  logic          eu_done,
  input  logic [7:0]    rbyte
);
  logic          full_q, full_n, word_q, word_n, half_q, half_n, rv_q, rv_n;
  logic [1:0]    op_q, op_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [15:0]   wdata_q, wdata_n, rd_q, rd_n;
  logic [7:0]    lo_q, lo_n;
  logic          accept;

  assign accept    = cmd_valid && !full_q;
  assign cmd_ready = !full_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign eu_req    = full_q && !rv_q;
  assign eu_addr   = addr_q + AW'(half_q);
  assign eu_write  = op_q[OP_WRITE_BIT];
  assign eu_io     = op_q[OP_IO_BIT];
  assign eu_wbyte  = half_q ? wdata_q[15:8] : wdata_q[7:0];
  assign eu_mid    = half_q;

  always_comb begin
    full_n  = full_q;
    word_n  = word_q;
    half_n  = half_q;
    rv_n    = rv_q;
    op_n    = op_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    rd_n    = rd_q;
    lo_n    = lo_q;
    if (accept) begin
      full_n  = 1'b1;
      op_n    = cmd_op;
      word_n  = cmd_word;
      addr_n  = cmd_addr;
      wdata_n = cmd_wdata;
      half_n  = 1'b0;
    end
    if (rsp_take && rv_q) rv_n = 1'b0;
    if (eu_done) begin
      if (word_q && !half_q) begin
        half_n = 1'b1;
        lo_n   = rbyte;
      end else begin
        full_n = 1'b0;
        half_n = 1'b0;
        rv_n   = 1'b1;
        if (op_q[OP_WRITE_BIT]) rd_n = 16'h0000;
        else if (word_q)        rd_n = {rbyte, lo_q};
        else                    rd_n = {8'h00, rbyte};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      word_q  <= 1'b0;
      half_q  <= 1'b0;
      rv_q    <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      lo_q    <= '0;
    end else begin
      full_q  <= full_n;
      word_q  <= word_n;
      half_q  <= half_n;
      rv_q    <= rv_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      rd_q    <= rd_n;
      lo_q    <= lo_n;
    end
  end

  // R4: a posted result stays put until it is taken
  p_rsp_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !rsp_take) |=> (rv_q && $stable(rd_q)));
  // R4: a taken command closes the slot
  p_slot_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: rtl/fbu_bus_seq.sv
module fbu_bus_seq
  import fbu_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eu_req,
  input  logic [AW-1:0] eu_addr,
  input  logic          eu_write,
  input  logic          eu_io,
  input  logic [7:0]    eu_wbyte,
  input  logic          eu_mid,
  output logic          eu_done,
  input  logic          lock,
  input  logic          q_room,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_start,
  output logic          fetch_end,
  output logic          fetch_abort,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic [2:0]    bus_tstate,
  output logic          bus_ale,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic [7:0]    rbyte
);
  tstate_e       state_q, state_n;
  logic          ti_q, ti_n;
  logic          cyc_fetch_q, cyc_write_q, cyc_io_q;
  logic [AW-1:0] cyc_addr_q, launch_addr;
  logic [7:0]    cyc_wbyte_q, rdata_q;
  logic          go_hold, launch_eu, launch_fetch, launch, in_strobe, in_cycle;

  always_comb begin
    go_hold      = (state_q == TS_T1) && hold_req && !lock && !eu_mid;
    launch_eu    = (state_q == TS_T1) && !go_hold && eu_req;
    launch_fetch = (state_q == TS_T1) && !go_hold && !eu_req && q_room;
    launch       = launch_eu || launch_fetch;
    launch_addr  = launch_eu ? eu_addr : fetch_addr;
    fetch_abort  = (state_q == TS_T2) && cyc_fetch_q && eu_req;
    state_n      = state_q;
    ti_n         = ti_q;
    case (state_q)
      TS_T1: begin
        if (go_hold)     state_n = TS_HOLD;
        else if (launch) state_n = TS_T2;
      end
      TS_T2: begin
        if (fetch_abort) begin
          state_n = TS_TI;
          ti_n    = 1'b0;
        end else begin
          state_n = TS_T3;
        end
      end
      TS_T3: state_n = TS_T4;
      TS_T4: state_n = TS_T1;
      TS_TI: begin
        if (!ti_q) ti_n = 1'b1;
        else       state_n = TS_T1;
      end
      TS_HOLD: if (!hold_req) state_n = TS_T1;
      default: state_n = TS_T1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_T1;
      ti_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      ti_q    <= ti_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_fetch_q <= 1'b0;
      cyc_write_q <= 1'b0;
      cyc_io_q    <= 1'b0;
      cyc_addr_q  <= '0;
      cyc_wbyte_q <= '0;
    end else if (launch) begin
      cyc_fetch_q <= launch_fetch;
      cyc_write_q <= launch_eu && eu_write;
      cyc_io_q    <= launch_eu && eu_io;
      cyc_addr_q  <= launch_addr;
      cyc_wbyte_q <= eu_wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata_q <= '0;
    else if (state_q == TS_T3) rdata_q <= bus_rdata;
  end

  assign in_strobe   = (state_q == TS_T2) || (state_q == TS_T3);
  assign in_cycle    = in_strobe || (state_q == TS_T4);
  assign bus_tstate  = state_q;
  assign bus_ale     = launch;
  assign bus_addr    = (state_q == TS_T1) ? launch_addr : cyc_addr_q;
  assign bus_rd      = in_strobe && !cyc_write_q;
  assign bus_wr      = in_strobe && cyc_write_q;
  assign bus_io      = (launch_eu && eu_io) || (in_cycle && cyc_io_q);
  assign bus_wdata   = (state_q == TS_T1) ? eu_wbyte : cyc_wbyte_q;
  assign hold_ack    = (state_q == TS_HOLD);
  assign eu_done     = (state_q == TS_T4) && !cyc_fetch_q;
  assign fetch_end   = (state_q == TS_T4) && cyc_fetch_q;
  assign fetch_start = launch_fetch;
  assign rbyte       = rdata_q;

  // R1: the data phases follow each other without gaps
  p_t3_to_t4_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T3) |=> (state_q == TS_T4));
  p_t4_to_t1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T4) |=> (state_q == TS_T1));
  // R8: an abandoned fetch yields exactly two idle clocks, then T1
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_abort |=> (state_q == TS_TI));
  p_ti_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_TI && !ti_q) |=> (state_q == TS_TI));
  p_ti_then_t1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_TI && ti_q) |=> (state_q == TS_T1));
  // R11: no hand-over of the bus under lock
  p_lock_keeps_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && state_q != TS_HOLD) |=> (state_q != TS_HOLD));
  // R6: the bus is never held between the halves of a word
  p_no_hold_mid_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eu_mid |-> (state_q != TS_HOLD));
endmodule

// File: rtl/fetch_bus_unit.sv
module fetch_bus_unit #(
  parameter int            AW         = 20,
  parameter int            QDEPTH     = 4,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_word,
  input  logic [AW-1:0] cmd_addr,
  input  logic [15:0]   cmd_wdata,
  input  logic          eu_lock,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  input  logic          rsp_take,
  input  logic          flush_req,
  input  logic [AW-1:0] flush_addr,
  output logic          q_valid,
  output logic [7:0]    q_byte,
  input  logic          q_pop,
  output logic [2:0]    bus_tstate,
  output logic          bus_ale,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          hold_req,
  output logic          hold_ack
);
  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          eu_req, eu_write, eu_io, eu_mid, eu_done;
  logic [AW-1:0] eu_addr, fetch_addr;
  logic [7:0]    eu_wbyte, rbyte;
  logic          q_room, fetch_start, fetch_end, fetch_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  fbu_eu_slot #(.AW(AW)) u_slot (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_word(cmd_word), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_take(rsp_take),
    .eu_req(eu_req), .eu_addr(eu_addr), .eu_write(eu_write), .eu_io(eu_io),
    .eu_wbyte(eu_wbyte), .eu_mid(eu_mid), .eu_done(eu_done), .rbyte(rbyte)
  );

  fbu_prefetch_q #(.DEPTH(QDEPTH), .AW(AW), .RESET_ADDR(RESET_ADDR)) u_queue (
    .clk(clk), .rst_n(rst_core_n),
    .flush(flush_req), .flush_addr(flush_addr),
    .fetch_start(fetch_start), .fetch_end(fetch_end), .fetch_abort(fetch_abort),
    .fetch_byte(rbyte), .pop(q_pop),
    .q_valid(q_valid), .q_byte(q_byte), .room(q_room), .fetch_addr(fetch_addr)
  );

  fbu_bus_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .eu_req(eu_req), .eu_addr(eu_addr), .eu_write(eu_write), .eu_io(eu_io),
    .eu_wbyte(eu_wbyte), .eu_mid(eu_mid), .eu_done(eu_done), .lock(eu_lock),
    .q_room(q_room), .fetch_addr(fetch_addr),
    .fetch_start(fetch_start), .fetch_end(fetch_end), .fetch_abort(fetch_abort),
    .hold_req(hold_req), .hold_ack(hold_ack),
    .bus_tstate(bus_tstate), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rbyte(rbyte)
  );
endmodule

// File: tb/fetch_bus_unit_tb.sv
module fetch_bus_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_word, eu_lock;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr, flush_addr, bus_addr;
  logic [15:0]   cmd_wdata, rsp_data;
  logic          rsp_valid, rsp_take, flush_req, q_valid, q_pop;
  logic [7:0]    q_byte, bus_wdata, bus_rdata;
  logic [2:0]    bus_tstate;
  logic          bus_ale, bus_rd, bus_wr, bus_io, hold_req, hold_ack;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_bus_unit #(.AW(AW), .QDEPTH(4), .RESET_ADDR('0)) u_dut (.*);

  function automatic logic [7:0] mdat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] iodat(input logic [AW-1:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction

  logic [AW-1:0] lat_addr = '0;
  logic          lat_io   = 1'b0;
  always @(posedge clk) if (bus_ale) begin
    lat_addr <= bus_addr;
    lat_io   <= bus_io;
  end
  assign bus_rdata = lat_io ? iodat(lat_addr) : mdat(lat_addr);

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic word,
                      input logic [AW-1:0] a, input logic [15:0] wd);
    cmd_op = op; cmd_word = word; cmd_addr = a; cmd_wdata = wd;
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic take_rsp();
    rsp_take = 1'b1;
    tick();
    rsp_take = 1'b0;
  endtask

  task automatic refill(input logic [AW-1:0] a);
    flush_addr = a; flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    tick(24);
  endtask

  task automatic pop_check(input string req, input logic [AW-1:0] a);
    for (int i = 0; i < 12 && !q_valid; i++) tick();
    check(req, "queue byte", {24'h0, q_byte}, {24'h0, mdat(a)});
    q_pop = 1'b1;
    tick();
    q_pop = 1'b0;
  endtask

  task automatic t_reset_and_fill();
    rst_n = 1'b0;
    tick(3);
    check("R1", "tstate in reset", bus_tstate, 0);
    check("R4", "cmd_ready in reset", cmd_ready, 1);
    check("R4", "rsp_valid in reset", rsp_valid, 0);
    check("R3", "q_valid in reset", q_valid, 0);
    check("R10", "hold_ack in reset", hold_ack, 0);
    rst_n = 1'b1;
    tick(30);
    for (int i = 0; i < 3; i++) begin
      check("R2", "parked ale", bus_ale, 0);
      check("R2", "parked tstate", bus_tstate, 0);
      check("R2", "parked strobes", {bus_rd, bus_wr}, 0);
      tick();
    end
    for (int i = 0; i < 4; i++) pop_check("R3", AW'(i));
  endtask

  task automatic t_byte_read();
    refill(20'h00100);
    send(2'b00, 1'b0, 20'h02345, 16'h0);
    check("R4", "slot closed", cmd_ready, 0);
    check("R1", "T1 ale", bus_ale, 1);
    check("R1", "T1 addr", bus_addr, 20'h02345);
    check("R4", "mem space", bus_io, 0);
    tick();
    check("R1", "T2", bus_tstate, 1);
    check("R1", "T2 rd", bus_rd, 1);
    tick();
    check("R1", "T3", bus_tstate, 2);
    tick();
    check("R1", "T4", bus_tstate, 3);
    check("R1", "no result at T4", rsp_valid, 0);
    tick();
    check("R1", "back at T1", bus_tstate, 0);
    check("R1", "result at T1", rsp_valid, 1);
    check("R5", "byte read data", rsp_data, {8'h00, mdat(20'h02345)});
    take_rsp();
    check("R4", "result taken", rsp_valid, 0);
  endtask

  task automatic t_word_read_hold();
    refill(20'h00100);
    send(2'b00, 1'b1, 20'h012FF, 16'h0);
    check("R6", "low byte addr", bus_addr, 20'h012FF);
    tick();
    hold_req = 1'b1;
    tick(3);
    check("R6", "high byte T1", bus_tstate, 0);
    check("R6", "high byte ale", bus_ale, 1);
    check("R6", "high byte addr", bus_addr, 20'h01300);
    check("R6", "no hold between halves", hold_ack, 0);
    tick(4);
    check("R5", "word ready", rsp_valid, 1);
    check("R5", "word data", rsp_data, {mdat(20'h01300), mdat(20'h012FF)});
    tick();
    check("R10", "held tstate", bus_tstate, 5);
    check("R10", "hold_ack", hold_ack, 1);
    hold_req = 1'b0;
    take_rsp();
    check("R10", "released", bus_tstate, 0);
    check("R10", "hold_ack low", hold_ack, 0);
  endtask

  task automatic t_io_word_write();
    refill(20'h00100);
    send(2'b11, 1'b1, 20'h00380, 16'hBEEF);
    check("R4", "io T1", bus_io, 1);
    tick();
    check("R6", "low write strobe", {bus_wr, bus_rd}, 2'b10);
    check("R6", "low write data", bus_wdata, 8'hEF);
    check("R4", "io during cycle", bus_io, 1);
    tick(4);
    check("R6", "high write strobe", bus_wr, 1);
    check("R6", "high write data", bus_wdata, 8'hBE);
    check("R6", "high write addr", bus_addr, 20'h00381);
    tick(3);
    check("R5", "write ack", rsp_valid, 1);
    check("R5", "write ack data", rsp_data, 16'h0000);
    take_rsp();
  endtask

  task automatic t_priority();
    refill(20'h00100);
    q_pop = 1'b1;
    send(2'b10, 1'b0, 20'h00060, 16'h0);
    q_pop = 1'b0;
    check("R7", "command wins T1", bus_ale, 1);
    check("R7", "command addr", bus_addr, 20'h00060);
    tick(4);
    check("R5", "io byte data", rsp_data, {8'h00, iodat(20'h00060)});
    take_rsp();
  endtask

  task automatic t_abort();
    refill(20'h00200);
    pop_check("R8", 20'h00200);
    check("R8", "fetch T1 ale", bus_ale, 1);
    check("R8", "fetch addr", bus_addr, 20'h00204);
    send(2'b00, 1'b0, 20'h03000, 16'h0);
    check("R8", "fetch T2", bus_tstate, 1);
    tick();
    check("R8", "idle 1", bus_tstate, 4);
    check("R8", "idle strobe", {bus_rd, bus_wr}, 0);
    tick();
    check("R8", "idle 2", bus_tstate, 4);
    tick();
    check("R8", "command T1", bus_ale, 1);
    check("R8", "command addr", bus_addr, 20'h03000);
    tick(4);
    check("R8", "command data", rsp_data, {8'h00, mdat(20'h03000)});
    take_rsp();
    tick(8);
    for (int i = 1; i < 6; i++) pop_check("R8", 20'h00200 + AW'(i));
  endtask

  task automatic t_flush_inflight();
    refill(20'h00400);
    pop_check("R9", 20'h00400);
    tick();
    flush_addr = 20'h00500; flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    check("R9", "queue empty", q_valid, 0);
    tick(24);
    for (int i = 0; i < 4; i++) pop_check("R9", 20'h00500 + AW'(i));
  endtask

  task automatic t_hold_then_cmd();
    refill(20'h00100);
    hold_req = 1'b1;
    tick();
    check("R10", "granted", hold_ack, 1);
    send(2'b00, 1'b0, 20'h00600, 16'h0);
    tick(2);
    check("R10", "still held", bus_tstate, 5);
    check("R10", "no ale held", bus_ale, 0);
    hold_req = 1'b0;
    tick();
    check("R10", "resume T1", bus_tstate, 0);
    check("R10", "command after hold", bus_addr, 20'h00600);
    tick(4);
    check("R10", "command data", rsp_data, {8'h00, mdat(20'h00600)});
    take_rsp();
  endtask

  task automatic t_lock();
    refill(20'h00100);
    eu_lock = 1'b1; hold_req = 1'b1;
    tick(3);
    check("R11", "no grant under lock", hold_ack, 0);
    check("R11", "stays T1", bus_tstate, 0);
    eu_lock = 1'b0;
    tick();
    check("R11", "grant after unlock", hold_ack, 1);
    hold_req = 1'b0;
    tick();
  endtask

  task automatic t_pending_result();
    refill(20'h00100);
    send(2'b00, 1'b0, 20'h00700, 16'h0);
    tick(4);
    check("R4", "first result", rsp_valid, 1);
    check("R4", "slot free", cmd_ready, 1);
    send(2'b00, 1'b0, 20'h00701, 16'h0);
    check("R4", "slot full", cmd_ready, 0);
    for (int i = 0; i < 3; i++) begin
      check("R4", "no cycle while pending", bus_ale, 0);
      tick();
    end
    check("R4", "first result kept", rsp_data, {8'h00, mdat(20'h00700)});
    take_rsp();
    check("R4", "second launches", bus_ale, 1);
    check("R4", "second addr", bus_addr, 20'h00701);
    tick(4);
    check("R4", "second data", rsp_data, {8'h00, mdat(20'h00701)});
    take_rsp();
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_word = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; eu_lock = 1'b0; rsp_take = 1'b0;
    flush_req = 1'b0; flush_addr = '0; q_pop = 1'b0; hold_req = 1'b0;
    t_reset_and_fill();
    t_byte_read();
    t_word_read_hold();
    t_io_word_write();
    t_priority();
    t_abort();
    t_flush_inflight();
    t_hold_then_cmd();
    t_lock();
    t_pending_result();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule